// File: doc/BRIEF.md
# Dual-Port RAM with Contention Arbiter

This block is a word-addressed memory with two fully independent ports, a left and a right. Each port has an active-low select, an active-low control-space select, an active-low output enable and one active-low write strobe per 8-bit byte lane. Both ports are sampled on every rising clock edge. Writes take effect at that edge. Read data comes out of a register one cycle later, with a valid flag. When a port is not reading, its data output is driven to zero in place of a high-impedance state.

When both ports select the same word, an arbiter decides which port owns it. The losing port receives an active-low busy flag, and its write is suppressed. A mode input selects master or slave operation.

- In master mode the block computes the busy flags itself.
- In slave mode the block drives no busy and instead obeys an external busy input on each port. This lets one master instance arbitrate for several slave instances that side by side form a wider word.

The word count is set by an address-width parameter: 14 gives the full 16K-word array, and the default is kept smaller.

Top module: `dpr_arb_ram`

## Requirements
- R1: A port is active only when its select is 0 and its control-space select is 1. An inactive port writes nothing, and in the next cycle its read valid is 0 and its read data is 0.
- R2: An active port with output enable 0 and all four write strobes 1 reads. In the next cycle it shows valid 1 and the word held before that edge's writes. With output enable 1, valid is 0 and data is 0.
- R3: Write strobe bit i at 0 on an active, unblocked port writes data bits 8i+7..8i into lane i at the clock edge. Lanes whose strobe is 1 keep their contents.
- R4: In master mode (mode input 1), suppose both ports start addressing the same word in the same cycle, with neither holding it before. The left port wins, and the right busy output goes to 0 in that same cycle.
- R5: In master mode, a port "holds" a word when it was active at that address in the previous cycle. If only one port holds the word when contention starts, that port wins and the other port's busy goes to 0. The two busy outputs are never 0 together.
- R6: A busy flag stays at 0 for as long as the contention lasts. It returns to 1 in the cycle that the winner changes address or is deselected.
- R7: A port that is busy in master mode has its write suppressed, so the stored word is unchanged. Its reads still return the stored word.
- R8: In slave mode (mode input 0), both busy outputs stay 1. A port whose busy input is 0 has its write suppressed, and a port whose busy input is 1 writes normally. In master mode the busy inputs are ignored.
- R9: While reset is held, both valid flags are 0, both data outputs are 0, both busy outputs are 1 and no ownership is remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| masterMode | input | 1 | 1: compute busy flags, 0: obey busy inputs |
| lCsN | input | 1 | Left select, active low |
| lSemN | input | 1 | Left control-space select, must be 1 for memory access |
| lOeN | input | 1 | Left output enable, active low |
| lWeN | input | LANES | Left per-lane write strobes, active low |
| lAddr | input | ADDR_W | Left word address |
| lWdata | input | LANES*LANE_W | Left write data |
| lBusyInN | input | 1 | Left external busy, active low (slave mode) |
| lBusyOutN | output | 1 | Left busy flag, active low (master mode) |
| lRdata | output | LANES*LANE_W | Left read data |
| lRdValid | output | 1 | Left read data valid |
| rCsN | input | 1 | Right select, active low |
| rSemN | input | 1 | Right control-space select, must be 1 for memory access |
| rOeN | input | 1 | Right output enable, active low |
| rWeN | input | LANES | Right per-lane write strobes, active low |
| rAddr | input | ADDR_W | Right word address |
| rWdata | input | LANES*LANE_W | Right write data |
| rBusyInN | input | 1 | Right external busy, active low (slave mode) |
| rBusyOutN | output | 1 | Right busy flag, active low (master mode) |
| rRdata | output | LANES*LANE_W | Right read data |
| rRdValid | output | 1 | Right read data valid |

## Verification
The bench builds the block with a 4-bit address and the default four 8-bit lanes, which gives 16 words. At that size every word can be written and read back. Every one of the 16 strobe patterns can also be applied at every address, and each result is compared against a merge computed in the bench. The contention cases then run on the same small array: a same-cycle tie, holder-wins in both directions, a persisting and a released busy flag, and slave-mode write blocking.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic [1:0] {OWN_NONE, OWN_LEFT, OWN_RIGHT} owner_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic wrOkL;  // left port may write (lanes chosen by its strobes)
    logic wrOkR;
    logic rdL;    // left port reads this cycle
    logic rdR;
  } strobe_t;
endpackage

// File: rtl/dpr_ctrl.sv
module dpr_ctrl
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              lCsN,
  input  logic              lSemN,
  input  logic              lOeN,
  input  logic [LANES-1:0]  lWeN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lBusyInN,
  input  logic              rCsN,
  input  logic              rSemN,
  input  logic              rOeN,
  input  logic [LANES-1:0]  rWeN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rBusyInN,
  output strobe_t           strb,
  output logic              lBusyOutN,
  output logic              rBusyOutN
);
  logic actL, actR, holdL, holdR, contend;
  logic busyL, busyR, blkL, blkR;
  logic prevActL, prevActR;
  logic [ADDR_W-1:0] prevAddrL, prevAddrR;
  owner_e ownerQ, winner;

  assign actL    = !lCsN && lSemN;
  assign actR    = !rCsN && rSemN;
  assign holdL   = prevActL && (prevAddrL == lAddr);
  assign holdR   = prevActR && (prevAddrR == rAddr);
  assign contend = masterMode && actL && actR && (lAddr == rAddr);

  // Ownership: keep the previous owner while contention lasts, else the holder wins, tie goes left
  always_comb begin
    winner = OWN_NONE;
    if (contend) begin
      if (ownerQ != OWN_NONE)    winner = ownerQ;
      else if (holdR && !holdL)  winner = OWN_RIGHT;
      else                       winner = OWN_LEFT;
    end
  end

  assign busyL = (winner == OWN_RIGHT);
  assign busyR = (winner == OWN_LEFT);

  assign blkL = masterMode ? busyL : !lBusyInN;
  assign blkR = masterMode ? busyR : !rBusyInN;

  always_comb begin
    strb.wrOkL = actL && !blkL;
    strb.wrOkR = actR && !blkR;
    strb.rdL   = actL && !lOeN && (&lWeN);
    strb.rdR   = actR && !rOeN && (&rWeN);
  end

  assign lBusyOutN = !busyL;
  assign rBusyOutN = !busyR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerQ    <= OWN_NONE;
      prevActL  <= 1'b0;
      prevActR  <= 1'b0;
      prevAddrL <= '0;
      prevAddrR <= '0;
    end else begin
      ownerQ    <= winner;
      prevActL  <= actL;
      prevActR  <= actR;
      prevAddrL <= lAddr;
      prevAddrR <= rAddr;
    end
  end

  assert_idle_no_strobe_R1: assert property (@(posedge clk) disable iff (!rstN)
    (lCsN || !lSemN) |-> !(strb.wrOkL || strb.rdL));
  assert_single_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(!lBusyOutN && !rBusyOutN));
  assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rBusyOutN |=> (!rBusyOutN || !contend));
  assert_blocked_no_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && !lBusyOutN) |-> !strb.wrOkL);
  assert_slave_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (lBusyOutN && rBusyOutN));
endmodule

// File: rtl/dpr_datapath.sv
module dpr_datapath
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic [LANES-1:0]        lWeN,
  input  logic [ADDR_W-1:0]       lAddr,
  input  logic [LANES*LANE_W-1:0] lWdata,
  input  logic [LANES-1:0]        rWeN,
  input  logic [ADDR_W-1:0]       rAddr,
  input  logic [LANES*LANE_W-1:0] rWdata,
  output logic [LANES*LANE_W-1:0] lRdata,
  output logic                    lRdValid,
  output logic [LANES*LANE_W-1:0] rRdata,
  output logic                    rRdValid
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] rdLaneL, rdLaneR;

    always_ff @(posedge clk) begin
      if (strb.wrOkL && !lWeN[g]) laneMem[lAddr] <= lWdata[g*LANE_W +: LANE_W];
      if (strb.wrOkR && !rWeN[g]) laneMem[rAddr] <= rWdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdLaneL <= '0;
        rdLaneR <= '0;
      end else begin
        rdLaneL <= strb.rdL ? laneMem[lAddr] : '0;
        rdLaneR <= strb.rdR ? laneMem[rAddr] : '0;
      end
    end

    assign lRdata[g*LANE_W +: LANE_W] = rdLaneL;
    assign rRdata[g*LANE_W +: LANE_W] = rdLaneR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lRdValid <= 1'b0;
      rRdValid <= 1'b0;
    end else begin
      lRdValid <= strb.rdL;
      rRdValid <= strb.rdR;
    end
  end

  assert_left_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !lRdValid |-> (lRdata == '0));
  assert_right_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !rRdValid |-> (rRdata == '0));
  assert_valid_follows_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdL |=> lRdValid);
endmodule

// File: rtl/dpr_arb_ram.sv
module dpr_arb_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    masterMode,
  input  logic                    lCsN,
  input  logic                    lSemN,
  input  logic                    lOeN,
  input  logic [LANES-1:0]        lWeN,
  input  logic [ADDR_W-1:0]       lAddr,
  input  logic [LANES*LANE_W-1:0] lWdata,
  input  logic                    lBusyInN,
  output logic                    lBusyOutN,
  output logic [LANES*LANE_W-1:0] lRdata,
  output logic                    lRdValid,
  input  logic                    rCsN,
  input  logic                    rSemN,
  input  logic                    rOeN,
  input  logic [LANES-1:0]        rWeN,
  input  logic [ADDR_W-1:0]       rAddr,
  input  logic [LANES*LANE_W-1:0] rWdata,
  input  logic                    rBusyInN,
  output logic                    rBusyOutN,
  output logic [LANES*LANE_W-1:0] rRdata,
  output logic                    rRdValid
);
  strobe_t strb;

  dpr_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) uCtrl (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .lCsN(lCsN), .lSemN(lSemN), .lOeN(lOeN), .lWeN(lWeN), .lAddr(lAddr), .lBusyInN(lBusyInN),
    .rCsN(rCsN), .rSemN(rSemN), .rOeN(rOeN), .rWeN(rWeN), .rAddr(rAddr), .rBusyInN(rBusyInN),
    .strb(strb), .lBusyOutN(lBusyOutN), .rBusyOutN(rBusyOutN)
  );

  dpr_datapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .lWeN(lWeN), .lAddr(lAddr), .lWdata(lWdata),
    .rWeN(rWeN), .rAddr(rAddr), .rWdata(rWdata),
    .lRdata(lRdata), .lRdValid(lRdValid), .rRdata(rRdata), .rRdValid(rRdValid)
  );
endmodule

// File: tb/tb_dpr_arb_ram.sv
`timescale 1ns/1ps
module tb_dpr_arb_ram;
  localparam int AW = 4;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rstN;
  logic masterMode;
  logic lCsN, lSemN, lOeN, lBusyInN, rCsN, rSemN, rOeN, rBusyInN;
  logic [3:0] lWeN, rWeN;
  logic [AW-1:0] lAddr, rAddr;
  logic [31:0] lWdata, rWdata, lRdata, rRdata;
  logic lBusyOutN, rBusyOutN, lRdValid, rRdValid;

  logic [31:0] model [NW];
  int nChk, nErr;
  bit done;

  always #2 clk = ~clk;

  dpr_arb_ram #(.ADDR_W(AW), .LANES(4), .LANE_W(8)) dut (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .lCsN(lCsN), .lSemN(lSemN), .lOeN(lOeN), .lWeN(lWeN), .lAddr(lAddr), .lWdata(lWdata),
    .lBusyInN(lBusyInN), .lBusyOutN(lBusyOutN), .lRdata(lRdata), .lRdValid(lRdValid),
    .rCsN(rCsN), .rSemN(rSemN), .rOeN(rOeN), .rWeN(rWeN), .rAddr(rAddr), .rWdata(rWdata),
    .rBusyInN(rBusyInN), .rBusyOutN(rBusyOutN), .rRdata(rRdata), .rRdValid(rRdValid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idleAll();
    lCsN = 1; lSemN = 1; lOeN = 1; lWeN = '1; lAddr = '0; lWdata = '0;
    rCsN = 1; rSemN = 1; rOeN = 1; rWeN = '1; rAddr = '0; rWdata = '0;
  endtask

  task automatic portL(input logic oe, input logic [3:0] we, input logic [AW-1:0] a, input logic [31:0] d);
    lCsN = 0; lSemN = 1; lOeN = oe; lWeN = we; lAddr = a; lWdata = d;
  endtask

  task automatic portR(input logic oe, input logic [3:0] we, input logic [AW-1:0] a, input logic [31:0] d);
    rCsN = 0; rSemN = 1; rOeN = oe; rWeN = we; rAddr = a; rWdata = d;
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] m);
    logic [31:0] r;
    r = old;
    for (int i = 0; i < 4; i++) if (m[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  initial begin
    logic [31:0] old, d;
    nChk = 0; nErr = 0; done = 0;
    masterMode = 1; lBusyInN = 1; rBusyInN = 1;
    idleAll();
    rstN = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 left valid", {31'd0, lRdValid}, 32'd0);
    chk("R9 right valid", {31'd0, rRdValid}, 32'd0);
    chk("R9 left data", lRdata, 32'd0);
    chk("R9 busy outs", {30'd0, lBusyOutN, rBusyOutN}, 32'd3);
    rstN = 1;
    tick();

    // R3 full-word writes, R2 read back on the other port
    for (int a = 0; a < NW; a++) begin
      d = 32'h1357_9BDF ^ (a * 32'h0101_0101);
      portL(1, 4'h0, a[AW-1:0], d);
      model[a] = d;
      tick();
    end
    idleAll();
    for (int a = 0; a < NW; a++) begin
      portR(0, 4'hF, a[AW-1:0], '0);
      tick();
      chk("R2 read data", rRdata, model[a]);
      chk("R2 read valid", {31'd0, rRdValid}, 32'd1);
    end

    // R3 every lane pattern at every word
    for (int a = 0; a < NW; a++) begin
      for (int m = 0; m < 16; m++) begin
        d = (a + 1) * 32'h0102_0304 + m * 32'h1111_1111;
        idleAll();
        portR(1, ~m[3:0], a[AW-1:0], d);
        tick();
        model[a] = merge(model[a], d, m[3:0]);
        idleAll();
        portL(0, 4'hF, a[AW-1:0], '0);
        tick();
        chk("R3 lane merge", lRdata, model[a]);
      end
    end

    // R1 deselected and control-space accesses do nothing
    idleAll();
    lCsN = 1; lWeN = 4'h0; lOeN = 0; lAddr = 0; lWdata = ~model[0];
    tick();
    chk("R1 deselected valid", {31'd0, lRdValid}, 32'd0);
    chk("R1 deselected data", lRdata, 32'd0);
    lCsN = 0; lSemN = 0;
    tick();
    chk("R1 control-space valid", {31'd0, lRdValid}, 32'd0);
    idleAll();
    portR(0, 4'hF, 0, '0);
    tick();
    chk("R1 word untouched", rRdata, model[0]);

    // R2 output enable high
    idleAll();
    portL(1, 4'hF, 1, '0);
    tick();
    chk("R2 oe high valid", {31'd0, lRdValid}, 32'd0);
    chk("R2 oe high data", lRdata, 32'd0);

    // R4 same-cycle tie goes left
    idleAll(); tick();
    portL(1, 4'h0, 2, 32'hAAAA_5555);
    portR(1, 4'h0, 2, 32'h5555_AAAA);
    #1;
    chk("R4 tie busy flags", {30'd0, lBusyOutN, rBusyOutN}, 32'd2);
    tick();
    model[2] = 32'hAAAA_5555;
    idleAll(); tick();
    portR(0, 4'hF, 2, '0);
    tick();
    chk("R4 winner data stored", rRdata, model[2]);

    // R5 left holds, right joins; R7 loser reads stored word; R6 persists then releases
    idleAll(); tick();
    portL(0, 4'hF, 3, '0);
    tick();
    old = model[3];
    portL(1, 4'h0, 3, 32'hC0FF_EE11);
    portR(0, 4'hF, 3, '0);
    #1;
    chk("R5 left holder wins", {30'd0, lBusyOutN, rBusyOutN}, 32'd2);
    tick();
    model[3] = 32'hC0FF_EE11;
    chk("R7 loser read before write", rRdata, old);
    portL(0, 4'hF, 3, '0);
    #1;
    chk("R6 busy persists", {31'd0, rBusyOutN}, 32'd0);
    tick();
    chk("R7 loser read after write", rRdata, model[3]);
    lCsN = 1;
    #1;
    chk("R6 busy released on deselect", {31'd0, rBusyOutN}, 32'd1);
    tick();

    // R5 right holds, left joins with a write that is blocked
    idleAll(); tick();
    portR(0, 4'hF, 5, '0);
    tick();
    portL(1, 4'h0, 5, 32'hDEAD_0001);
    #1;
    chk("R5 right holder wins", {30'd0, lBusyOutN, rBusyOutN}, 32'd1);
    tick();
    for (int k = 0; k < 3; k++) begin
      portL(0, 4'hF, 5, '0);
      #1;
      chk("R6 left busy persists", {31'd0, lBusyOutN}, 32'd0);
      tick();
      chk("R7 blocked write left word", lRdata, model[5]);
    end
    rAddr = 6;
    #1;
    chk("R6 busy released on move", {31'd0, lBusyOutN}, 32'd1);
    tick();

    // R8 slave mode obeys busy inputs
    masterMode = 0;
    idleAll(); tick();
    portL(1, 4'h0, 7, 32'h7777_0000);
    portR(1, 4'h0, 8, 32'h0000_8888);
    rBusyInN = 0; lBusyInN = 1;
    #1;
    chk("R8 slave busy outs", {30'd0, lBusyOutN, rBusyOutN}, 32'd3);
    tick();
    model[7] = 32'h7777_0000;
    rBusyInN = 1;
    idleAll();
    portR(0, 4'hF, 7, '0);
    portL(0, 4'hF, 8, '0);
    tick();
    chk("R8 unblocked write", rRdata, model[7]);
    chk("R8 blocked write", lRdata, model[8]);

    // R8 master mode ignores busy input
    masterMode = 1; lBusyInN = 0;
    idleAll(); tick();
    portL(1, 4'h0, 9, 32'h9999_0009);
    tick();
    model[9] = 32'h9999_0009;
    lBusyInN = 1;
    idleAll();
    portL(0, 4'hF, 9, '0);
    tick();
    chk("R8 busy input ignored in master", lRdata, model[9]);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      nErr++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end
endmodule